// File: doc/BRIEF.md
# Idle and Slow-Idle Clock Enable Divider

This block produces the clock enables that a processor core and its peripherals run from: one enable for the core, and separate enables for the serial-port clock, the external clock output and the timer tick. During normal operation every enable is high on every cycle. An idle command stops the core. A plain idle command leaves the peripheral enables at full rate. A slow idle command carries a two-bit divisor code, and while the block is in slow idle every peripheral enable pulses only once per divisor period.

Interrupts end both idle modes. In plain idle the first cycle that shows a pending unmasked interrupt raises the wake strobe. In slow idle the interrupt is held until the next divided tick, so the response time is bounded by the divisor. The full-rate enables return on the cycle after the wake strobe. Direct-memory cycle steals are granted in every mode. The clock output can also be gated on its own.

Top module: `idle_clkdiv`

## Requirements
- R1: While reset is asserted and in the cycle after reset is released, core_en, sclk_en and timer_en are 1, wake is 0, and clkout_en is 1 unless clkout_off is set.
- R2: When idle_req is high in normal mode with idle_slow low, core_en stays 1 in that cycle and is 0 from the next cycle on, while sclk_en and timer_en stay 1 on every cycle.
- R3: In plain idle, wake is 1 in the same cycle in which irq_pend is first seen high, and core_en is 1 again in the following cycle when dma_req is low.
- R4: A slow idle command (idle_req and idle_slow high) with code c on idle_div sets the divisor D = 2^(BASE_SHIFT+c). Numbering the cycles after the command 1, 2, 3 and so on, sclk_en and timer_en are 1 exactly in the cycles whose number is a multiple of D.
- R5: Throughout slow idle core_en is 0.
- R6: If irq_pend first goes high in slow-idle cycle k and then stays high, wake is 1 only in cycle ceil(k/D)*D, the first divided tick at or after k. All enables are at full rate in the next cycle.
- R7: dma_grant equals dma_req in every mode. In normal mode core_en is 0 in any cycle where dma_req is 1.
- R8: clkout_en is 0 whenever clkout_off is 1. Otherwise it equals sclk_en.
- R9: An idle_req that arrives while the block is already in plain or slow idle is ignored. The mode and divisor stay unchanged.
- R10: wake never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_req | input | 1 | Idle command strobe |
| idle_slow | input | 1 | Command carries a divisor (slow idle) |
| idle_div | input | CODE_W | Divisor code, D = 2^(BASE_SHIFT+code) |
| irq_pend | input | 1 | Unmasked interrupt pending |
| dma_req | input | 1 | Cycle-steal request |
| clkout_off | input | 1 | Gate the clock-output enable |
| core_en | output | 1 | Core clock enable |
| sclk_en | output | 1 | Serial-port clock enable |
| clkout_en | output | 1 | Clock-output enable |
| timer_en | output | 1 | Timer tick enable |
| dma_grant | output | 1 | Cycle-steal grant |
| wake | output | 1 | One-cycle wake strobe |

## Verification
The bench builds the block with BASE_SHIFT = 1, which gives divisors of 2, 4, 8 and 16 in place of 16 through 128. At these sizes the bench can cover every divisor code and every interrupt arrival offset from the first slow-idle cycle to one cycle past the first tick. That covers every wake latency, including an interrupt that lands exactly on a tick. The same sweeps also vary the clock-output gate, the steal requests, and a second idle command sent while the block is already idle.

// File: rtl/idle_clkdiv_pkg.sv
package idle_clkdiv_pkg;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_IDLE = 2'd1,
      ST_SLOW = 2'd2
   } idle_state_e;

endpackage

// File: rtl/idle_clkdiv_prescale.sv
module idle_clkdiv_prescale #(
   parameter int BASE_SHIFT = 4,
   parameter int CODE_W     = 2,
   localparam int CNT_W     = BASE_SHIFT + (1 << CODE_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] span_mask;

   // bit i takes part in the terminal compare when it lies below the divisor exponent
   for (genvar i = 0; i < CNT_W; i++) begin : g_mask
      assign span_mask[i] = (i < (BASE_SHIFT + int'(code)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !active) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   assign tick = active && (&(cnt_q | ~span_mask));

endmodule

// File: rtl/idle_clkdiv_ctrl.sv
module idle_clkdiv_ctrl
   import idle_clkdiv_pkg::*;
#(
   parameter int CODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idle_req,
   input  logic              idle_slow,
   input  logic [CODE_W-1:0] idle_div,
   input  logic              irq_pend,
   input  logic              tick,
   output idle_state_e       state,
   output logic [CODE_W-1:0] code,
   output logic              wake
);

   idle_state_e       state_d;
   logic [CODE_W-1:0] code_d;
   logic              seen_q, seen_d;

   always_comb begin
      state_d = state;
      code_d  = code;
      seen_d  = seen_q;
      wake    = 1'b0;
      unique case (state)
         ST_RUN: begin
            seen_d = 1'b0;
            if (idle_req) begin
               state_d = idle_slow ? ST_SLOW : ST_IDLE;
               code_d  = idle_div;
            end
         end
         ST_IDLE: begin
            if (irq_pend) begin
               wake    = 1'b1;
               state_d = ST_RUN;
            end
         end
         ST_SLOW: begin
            if (irq_pend) seen_d = 1'b1;
            if (tick && (irq_pend || seen_q)) begin
               wake    = 1'b1;
               state_d = ST_RUN;
               seen_d  = 1'b0;
            end
         end
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_RUN;
         code   <= '0;
         seen_q <= 1'b0;
      end else begin
         state  <= state_d;
         code   <= code_d;
         seen_q <= seen_d;
      end
   end

endmodule

// File: rtl/idle_clkdiv_gate.sv
module idle_clkdiv_gate
   import idle_clkdiv_pkg::*;
(
   input  idle_state_e state,
   input  logic        tick,
   input  logic        dma_req,
   input  logic        clkout_off,
   output logic        core_en,
   output logic        sclk_en,
   output logic        clkout_en,
   output logic        timer_en,
   output logic        dma_grant
);

   logic periph_en;

   always_comb begin
      unique case (state)
         ST_RUN:  begin core_en = !dma_req; periph_en = 1'b1; end
         ST_IDLE: begin core_en = 1'b0;     periph_en = 1'b1; end
         ST_SLOW: begin core_en = 1'b0;     periph_en = tick; end
         default: begin core_en = 1'b0;     periph_en = 1'b1; end
      endcase
   end

   assign sclk_en   = periph_en;
   assign timer_en  = periph_en;
   assign clkout_en = periph_en && !clkout_off;
   assign dma_grant = dma_req;

endmodule

// File: rtl/idle_clkdiv.sv
module idle_clkdiv
   import idle_clkdiv_pkg::*;
#(
   parameter int BASE_SHIFT = 4,
   parameter int CODE_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idle_req,
   input  logic              idle_slow,
   input  logic [CODE_W-1:0] idle_div,
   input  logic              irq_pend,
   input  logic              dma_req,
   input  logic              clkout_off,
   output logic              core_en,
   output logic              sclk_en,
   output logic              clkout_en,
   output logic              timer_en,
   output logic              dma_grant,
   output logic              wake
);

   if (BASE_SHIFT < 1 || BASE_SHIFT > 16) begin : g_bad_shift
      $error("idle_clkdiv: BASE_SHIFT out of range");
   end
   if (CODE_W < 1 || CODE_W > 3) begin : g_bad_code
      $error("idle_clkdiv: CODE_W out of range");
   end

   idle_state_e       state;
   logic [CODE_W-1:0] code;
   logic              tick;

   idle_clkdiv_ctrl #(.CODE_W(CODE_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .idle_req (idle_req),
      .idle_slow(idle_slow),
      .idle_div (idle_div),
      .irq_pend (irq_pend),
      .tick     (tick),
      .state    (state),
      .code     (code),
      .wake     (wake)
   );

   idle_clkdiv_prescale #(.BASE_SHIFT(BASE_SHIFT), .CODE_W(CODE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .active(state == ST_SLOW),
      .code  (code),
      .tick  (tick)
   );

   idle_clkdiv_gate u_gate (
      .state     (state),
      .tick      (tick),
      .dma_req   (dma_req),
      .clkout_off(clkout_off),
      .core_en   (core_en),
      .sclk_en   (sclk_en),
      .clkout_en (clkout_en),
      .timer_en  (timer_en),
      .dma_grant (dma_grant)
   );

endmodule

// File: rtl/idle_clkdiv_chk.sv
module idle_clkdiv_chk (
   input logic clk,
   input logic rst_n,
   input logic dma_req,
   input logic clkout_off,
   input logic core_en,
   input logic sclk_en,
   input logic clkout_en,
   input logic timer_en,
   input logic dma_grant,
   input logic wake
);

   p_wake_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !wake);

   p_wake_resume_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> (core_en == !dma_req) && sclk_en);

   p_wake_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> sclk_en && !core_en);

   p_core_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_en |-> !core_en);

   p_same_ratio_r4: assert property (@(posedge clk) disable iff (!rst_n)
      timer_en == sclk_en);

   p_clkout_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clkout_en == (sclk_en && !clkout_off));

   p_steal_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dma_grant == dma_req);

   p_steal_core_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> !core_en);

endmodule

bind idle_clkdiv idle_clkdiv_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dma_req   (dma_req),
   .clkout_off(clkout_off),
   .core_en   (core_en),
   .sclk_en   (sclk_en),
   .clkout_en (clkout_en),
   .timer_en  (timer_en),
   .dma_grant (dma_grant),
   .wake      (wake)
);

// File: tb/sim_idle_clkdiv.sv
module sim_idle_clkdiv;

   localparam int CLK_PERIOD = 10;
   localparam int BS         = 1;
   localparam int CW         = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          idle_req, idle_slow, irq_pend, dma_req, clkout_off;
   logic [CW-1:0] idle_div;
   logic          core_en, sclk_en, clkout_en, timer_en, dma_grant, wake;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   idle_clkdiv #(.BASE_SHIFT(BS), .CODE_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_slow(idle_slow),
      .idle_div(idle_div), .irq_pend(irq_pend), .dma_req(dma_req),
      .clkout_off(clkout_off), .core_en(core_en), .sclk_en(sclk_en),
      .clkout_en(clkout_en), .timer_en(timer_en), .dma_grant(dma_grant),
      .wake(wake)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic quiet();
      idle_req = 0; idle_slow = 0; idle_div = '0; irq_pend = 0; dma_req = 0;
   endtask

   // plain idle with interrupt in cycle k0
   task automatic plain_run(input int k0, input bit off);
      @(negedge clk);
      quiet(); idle_req = 1; clkout_off = off;
      #1 chk("R2 command cycle core_en", core_en, 1'b1);
      for (int k = 1; k <= k0; k++) begin
         @(negedge clk);
         quiet(); irq_pend = (k == k0); dma_req = k[0];
         idle_req = (k == 1); idle_slow = 1'b1;   // R9: ignored while idle
         #1;
         chk("R2 core stalled", core_en, 1'b0);
         chk("R2 R9 sclk full rate", sclk_en, 1'b1);
         chk("R2 timer full rate", timer_en, 1'b1);
         chk("R3 wake", wake, k == k0);
         chk("R7 grant", dma_grant, k[0]);
         chk("R8 clkout", clkout_en, !off);
      end
      @(negedge clk);
      quiet();
      #1;
      chk("R3 resume core", core_en, 1'b1);
      chk("R10 wake low", wake, 1'b0);
   endtask

   // slow idle with code c, interrupt from cycle k0 on
   task automatic slow_run(input int c, input int k0, input bit off);
      int d, kw;
      d  = 1 << (BS + c);
      kw = ((k0 + d - 1) / d) * d;
      @(negedge clk);
      quiet(); idle_req = 1; idle_slow = 1; idle_div = CW'(c); clkout_off = off;
      #1 chk("R2 command cycle core_en", core_en, 1'b1);
      for (int k = 1; k <= kw; k++) begin
         @(negedge clk);
         quiet(); irq_pend = (k >= k0); dma_req = k[0];
         idle_req = (k == 1); idle_div = ~CW'(c);   // R9: ignored while idle
         #1;
         chk("R4 R9 sclk tick", sclk_en, (k % d) == 0);
         chk("R4 timer tick", timer_en, (k % d) == 0);
         chk("R5 core stalled", core_en, 1'b0);
         chk("R6 wake", wake, k == kw);
         chk("R7 grant", dma_grant, k[0]);
         chk("R8 clkout", clkout_en, ((k % d) == 0) && !off);
      end
      @(negedge clk);
      quiet();
      #1;
      chk("R6 resume core", core_en, 1'b1);
      chk("R6 resume sclk", sclk_en, 1'b1);
      chk("R6 resume timer", timer_en, 1'b1);
      chk("R10 wake low", wake, 1'b0);
   endtask

   initial begin
      rst_n = 0; quiet(); clkout_off = 0;
      repeat (2) @(negedge clk);
      #1;
      chk("R1 reset core_en", core_en, 1'b1);
      chk("R1 reset sclk_en", sclk_en, 1'b1);
      chk("R1 reset timer_en", timer_en, 1'b1);
      chk("R1 reset clkout_en", clkout_en, 1'b1);
      chk("R1 reset wake", wake, 1'b0);
      @(negedge clk);
      rst_n = 1;
      #1;
      chk("R1 after reset core_en", core_en, 1'b1);
      chk("R1 after reset wake", wake, 1'b0);

      // normal mode: interrupt alone does nothing, steals take the core, clock output gate
      @(negedge clk);
      irq_pend = 1; dma_req = 1; clkout_off = 1;
      #1;
      chk("R7 run steal core", core_en, 1'b0);
      chk("R7 run grant", dma_grant, 1'b1);
      chk("R8 run clkout off", clkout_en, 1'b0);
      chk("R1 run no wake", wake, 1'b0);
      @(negedge clk);
      quiet(); clkout_off = 0;
      #1;
      chk("R7 run core back", core_en, 1'b1);
      chk("R8 run clkout on", clkout_en, 1'b1);

      for (int k0 = 1; k0 <= 4; k0++) plain_run(k0, k0[0]);

      for (int c = 0; c < (1 << CW); c++) begin
         for (int k0 = 1; k0 <= (1 << (BS + c)) + 1; k0++) begin
            slow_run(c, k0, k0[1]);
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule